// File: doc/BRIEF.md
# Memory-Mapped Arithmetic Slave

This block is a slave on an AHB-style system bus that turns three register writes into an arithmetic result. Software writes two 32-bit operands and an operation code. It then reads back the sum, difference or product from a fourth register. Transfers follow the usual two-stage pipeline: the address and control are captured when a transfer is accepted, and the write data is committed in the following cycle.

The arithmetic path is pipelined, and the multiplier sets its speed. A read of the result register is therefore held off with inserted wait states. The returned value always reflects the most recent operand and operation writes, even when the read directly follows the last write of a burst. Every other access completes with no wait. The response is always OKAY.

Top module: `ahb_calc_slave`

## Requirements
- R1: While reset is asserted and after it is released, `hready_out` is 1 and `hresp` is 2'b00. The operand registers, the operation register and the result all read back as 0.
- R2: The register offsets are: first operand 0x04, second operand 0x08, operation code 0x0C, result 0x10. The operand and operation registers read back the last value written to them.
- R3: Operation code 5 makes the result the 32-bit sum of the operands. For example, 9 and 6 give 15.
- R4: Operation code 6 makes the result the first operand minus the second, wrapped to 32 bits. For example, 10 and 5 give 5, and 3 and 5 give 0xFFFFFFFE.
- R5: Operation code 7 makes the result the low 32 bits of the product. For example, 10 and 5 give 50, and 0x10000 times 0x10003 gives 0x00030000.
- R6: Any operation code other than 5, 6 or 7 gives a result of 0.
- R7: A read of 0x10 holds `hready_out` low for exactly WAIT_CYCLES cycles of its data phase and then completes with the current result. This also holds when the read's address phase shares a cycle with the data phase of the final write.
- R8: Writes, and reads of any offset other than 0x10, complete with zero wait states. `hresp` is always 2'b00 (OKAY).
- R9: An incrementing burst of three word writes starting at 0x04 (one NONSEQ beat, then two SEQ beats) has the same effect as three single NONSEQ writes.
- R10: A transfer whose `htrans` is IDLE (2'b00) or BUSY (2'b01) writes nothing and completes with zero wait.
- R11: Writes are discarded when they target 0x10, target an unmapped offset, or have `hsize` other than word (3'b010).
- R12: Reads of unmapped offsets return 0 with zero wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte offset inside the slave window |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size; only word writes take effect |
| hburst | input | 3 | Burst type |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready_in | input | 1 | Bus-wide ready; a transfer is accepted when it is high |
| hrdata | output | DATA_W | Read data |
| hready_out | output | 1 | Slave ready; low during inserted wait states |
| hresp | output | 2 | Transfer response, always OKAY |

## Verification
A stale arithmetic pipeline or a wait counter that runs one cycle short shows up as a wrong value on the very first result read after the operands change. A counter that runs long shows up as an extra low cycle on `hready_out`, so the number of stall cycles is counted for every read. A wrongly latched data-phase select shows up at the ports on the next readback of the register it hit, or of the register it should have hit. Reads are therefore placed right after every write pattern, including the pipelined read that shares a cycle with the last burst beat.

// File: rtl/calc_pkg.sv
package calc_pkg;

  // Register byte offsets inside the slave window
  localparam int unsigned OFF_OPA = 32'h04;
  localparam int unsigned OFF_OPB = 32'h08;
  localparam int unsigned OFF_OPC = 32'h0C;
  localparam int unsigned OFF_RES = 32'h10;

  // Operation codes
  localparam int unsigned OPC_ADD = 5;
  localparam int unsigned OPC_SUB = 6;
  localparam int unsigned OPC_MUL = 7;

  // Bus encodings
  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [1:0] RESP_OKAY    = 2'b00;

  // Decoded register select; operand registers take values 1..3
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_OPA  = 3'd1,
    SEL_OPB  = 3'd2,
    SEL_OPC  = 3'd3,
    SEL_RES  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/calc_rst_sync.sv
module calc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/calc_wait_gen.sv
// Inserts a fixed number of stall cycles after a result read is accepted.
module calc_wait_gen #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic stall
);

  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (start) begin
      cnt_d = CNT_W'(WAIT_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign stall = (cnt_q != '0);

endmodule

// File: rtl/calc_bus_ctrl.sv
// Address-phase capture, data-phase tracking and wait-state control.
module calc_bus_ctrl
  import calc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic              hready_in,
  output logic              wr_en,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel,
  output logic              hready_out
);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    if (a == ADDR_W'(OFF_OPA))      s = SEL_OPA;
    else if (a == ADDR_W'(OFF_OPB)) s = SEL_OPB;
    else if (a == ADDR_W'(OFF_OPC)) s = SEL_OPC;
    else if (a == ADDR_W'(OFF_RES)) s = SEL_RES;
    else                            s = SEL_NONE;
    return s;
  endfunction

  logic     accept;
  reg_sel_e ap_sel;
  logic     dp_wr_q, dp_wr_d;
  logic     dp_rd_q, dp_rd_d;
  reg_sel_e dp_sel_q, dp_sel_d;
  logic     res_start;
  logic     stall;

  // Only NONSEQ and SEQ transfers (htrans[1] set) are taken
  assign accept = hsel && hready_in && htrans[1];
  assign ap_sel = decode(haddr);

  always_comb begin
    dp_wr_d  = accept && hwrite && (hsize == SIZE_WORD);
    dp_rd_d  = accept && !hwrite;
    dp_sel_d = accept ? ap_sel : SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_wr_q  <= 1'b0;
      dp_rd_q  <= 1'b0;
      dp_sel_q <= SEL_NONE;
    end else if (hready_in) begin
      dp_wr_q  <= dp_wr_d;
      dp_rd_q  <= dp_rd_d;
      dp_sel_q <= dp_sel_d;
    end
  end

  assign res_start = accept && !hwrite && (ap_sel == SEL_RES);

  calc_wait_gen #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (res_start),
    .stall (stall)
  );

  assign hready_out = !stall;
  assign wr_en      = dp_wr_q && hready_in;
  assign wr_sel     = dp_sel_q;
  assign rd_sel     = dp_rd_q ? dp_sel_q : SEL_NONE;

endmodule

// File: rtl/calc_regfile.sv
// Operand and operation registers plus the read-back multiplexer.
module calc_regfile
  import calc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  reg_sel_e          rd_sel,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] opc,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NUM_REGS = 3;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic en;
    assign en = wr_en && (wr_sel == reg_sel_e'(3'(i + 1)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (en) begin
        regs_q[i] <= wdata;
      end
    end
  end

  assign opa = regs_q[0];
  assign opb = regs_q[1];
  assign opc = regs_q[2];

  always_comb begin
    case (rd_sel)
      SEL_OPA: rdata = regs_q[0];
      SEL_OPB: rdata = regs_q[1];
      SEL_OPC: rdata = regs_q[2];
      SEL_RES: rdata = result;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/calc_alu.sv
// Registered arithmetic unit; an optional input stage relieves the multiplier path.
module calc_alu
  import calc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] compute(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] c
  );
    logic [DATA_W-1:0] r;
    if (c == DATA_W'(OPC_ADD))      r = a + b;
    else if (c == DATA_W'(OPC_SUB)) r = a - b;
    else if (c == DATA_W'(OPC_MUL)) r = a * b;
    else                            r = '0;
    return r;
  endfunction

  logic [DATA_W-1:0] res_q;

  if (LATENCY >= 2) begin : g_staged
    logic [DATA_W-1:0] a_q, b_q, c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q   <= '0;
        b_q   <= '0;
        c_q   <= '0;
        res_q <= '0;
      end else begin
        a_q   <= opa;
        b_q   <= opb;
        c_q   <= opc;
        res_q <= compute(a_q, b_q, c_q);
      end
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
      end else begin
        res_q <= compute(opa, opb, opc);
      end
    end
  end

  assign result = res_q;

endmodule

// File: rtl/ahb_calc_slave.sv
module ahb_calc_slave
  import calc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned WAIT_CYCLES = 2,
  parameter int unsigned ALU_LATENCY = 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [2:0]        hburst,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready_in,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready_out,
  output logic [1:0]        hresp
);

  logic              rst_sync_n;
  logic              wr_en;
  reg_sel_e          wr_sel;
  reg_sel_e          rd_sel;
  logic [DATA_W-1:0] opa, opb, opc, result;

  calc_rst_sync u_rst (
    .clk    (hclk),
    .arst_n (hresetn),
    .rst_n  (rst_sync_n)
  );

  calc_bus_ctrl #(
    .ADDR_W      (ADDR_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_ctrl (
    .clk        (hclk),
    .rst_n      (rst_sync_n),
    .hsel       (hsel),
    .haddr      (haddr),
    .htrans     (htrans),
    .hwrite     (hwrite),
    .hsize      (hsize),
    .hready_in  (hready_in),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .rd_sel     (rd_sel),
    .hready_out (hready_out)
  );

  calc_regfile #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk    (hclk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wdata  (hwdata),
    .rd_sel (rd_sel),
    .result (result),
    .opa    (opa),
    .opb    (opb),
    .opc    (opc),
    .rdata  (hrdata)
  );

  calc_alu #(
    .DATA_W  (DATA_W),
    .LATENCY (ALU_LATENCY)
  ) u_alu (
    .clk    (hclk),
    .rst_n  (rst_sync_n),
    .opa    (opa),
    .opb    (opb),
    .opc    (opc),
    .result (result)
  );

  assign hresp = RESP_OKAY;

endmodule

// File: rtl/calc_slave_checker.sv
module calc_slave_checker #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hburst,
  input logic              hready_in,
  input logic              hready_out
);

  localparam logic [ADDR_W-1:0] RES_ADDR = ADDR_W'(calc_pkg::OFF_RES);
  localparam int unsigned       LOW_W    = $clog2(WAIT_CYCLES + 2) + 1;

  logic             take;
  logic [LOW_W-1:0] low_q;

  assign take = hsel && hready_in && htrans[1];

  // Consecutive cycles with hready_out low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (!hready_out) begin
      if (low_q != '1) low_q <= low_q + 1'b1;
    end else begin
      low_q <= '0;
    end
  end

  AST_RESULT_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hwrite && haddr == RES_ADDR) |=> !hready_out); // R7

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= LOW_W'(WAIT_CYCLES)); // R7

  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hwrite) |=> hready_out); // R8

  AST_OTHER_READ_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hwrite && haddr != RES_ADDR) |=> hready_out); // R8

  AST_BURST_BEAT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hwrite && htrans == calc_pkg::TRANS_SEQ && hburst != 3'b000) |=> hready_out); // R9

  AST_IDLE_BUSY_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready_in && !htrans[1]) |=> hready_out); // R10

endmodule

bind ahb_calc_slave calc_slave_checker #(
  .ADDR_W      (ADDR_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_checker (
  .clk        (hclk),
  .rst_n      (rst_sync_n),
  .hsel       (hsel),
  .haddr      (haddr),
  .htrans     (htrans),
  .hwrite     (hwrite),
  .hburst     (hburst),
  .hready_in  (hready_in),
  .hready_out (hready_out)
);

// File: tb/ahb_calc_slave_bench.sv
module ahb_calc_slave_bench;

  localparam int unsigned WAIT = 2;

  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [2:0] SZ_WORD = 3'b010, SZ_HALF = 3'b001;
  localparam logic [2:0] BR_SINGLE = 3'b000, BR_INCR = 3'b001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsel;
  logic [7:0]  haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [31:0] hwdata;
  logic [31:0] hrdata;
  logic        hready_out;
  logic [1:0]  hresp;

  always #5 clk = ~clk;

  ahb_calc_slave #(
    .WAIT_CYCLES (WAIT)
  ) u_ahb_calc_slave (
    .hclk       (clk),
    .hresetn    (rst_n),
    .hsel       (hsel),
    .haddr      (haddr),
    .htrans     (htrans),
    .hwrite     (hwrite),
    .hsize      (hsize),
    .hburst     (hburst),
    .hwdata     (hwdata),
    .hready_in  (hready_out),
    .hrdata     (hrdata),
    .hready_out (hready_out),
    .hresp      (hresp)
  );

  typedef struct {
    logic [31:0] data;
    int          waits;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   resp_bad = 0;
  bit   rd_pend  = 1'b0;
  int   low_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] op);
    if (op == 32'd5) return a + b;
    if (op == 32'd6) return a - b;
    if (op == 32'd7) return a * b;
    return 32'd0;
  endfunction

  // Monitor / scoreboard: compares each completed read with the next expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (hresp != 2'b00) resp_bad++;
      if (rd_pend) begin
        if (!hready_out) begin
          low_seen++;
        end else begin
          exp_t e;
          if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected read completion", hrdata, 32'h0);
          end else begin
            e = sb_q.pop_front();
            check(hrdata === e.data, e.req, "read data", hrdata, e.data);
            check(low_seen == e.waits, e.req, "wait states", low_seen, e.waits);
          end
          rd_pend = 1'b0;
        end
      end
      if (hready_out && hsel && htrans[1] && !hwrite) begin
        rd_pend  = 1'b1;
        low_seen = 0;
      end
    end
  end

  task automatic idle_bus();
    hsel   = 1'b0;
    haddr  = 8'h00;
    htrans = T_IDLE;
    hwrite = 1'b0;
    hsize  = SZ_WORD;
    hburst = BR_SINGLE;
  endtask

  task automatic addr_ph(input logic wr, input logic [7:0] a, input logic [1:0] tr,
                         input logic [2:0] sz, input logic [2:0] br);
    hsel   = 1'b1;
    haddr  = a;
    htrans = tr;
    hwrite = wr;
    hsize  = sz;
    hburst = br;
  endtask

  task automatic finish_dp();
    while (!hready_out) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d,
                     input logic [1:0] tr = T_NSEQ, input logic [2:0] sz = SZ_WORD);
    @(posedge clk); #1;
    addr_ph(1'b1, a, tr, sz, BR_SINGLE);
    @(posedge clk); #1;
    idle_bus();
    hwdata = d;
    finish_dp();
  endtask

  task automatic rd1(input logic [7:0] a, input logic [31:0] exp, input int waits,
                     input string req);
    exp_t e;
    @(posedge clk); #1;
    addr_ph(1'b0, a, T_NSEQ, SZ_WORD, BR_SINGLE);
    e.data = exp; e.waits = waits; e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    idle_bus();
    finish_dp();
  endtask

  // Three-beat incrementing burst, with the result read pipelined behind the last beat
  task automatic burst_calc(input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] op, input string req);
    exp_t e;
    @(posedge clk); #1;
    addr_ph(1'b1, 8'h04, T_NSEQ, SZ_WORD, BR_INCR);
    @(posedge clk); #1;
    addr_ph(1'b1, 8'h08, T_SEQ, SZ_WORD, BR_INCR);
    hwdata = a;
    @(posedge clk); #1;
    addr_ph(1'b1, 8'h0C, T_SEQ, SZ_WORD, BR_INCR);
    hwdata = b;
    @(posedge clk); #1;
    addr_ph(1'b0, 8'h10, T_NSEQ, SZ_WORD, BR_SINGLE);
    hwdata = op;
    e.data = model(a, b, op); e.waits = WAIT; e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    idle_bus();
    finish_dp();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    hwdata = 32'h0;
    idle_bus();
    repeat (3) @(posedge clk);
    #1;
    check(hready_out === 1'b1, "R1", "hready_out in reset", {31'h0, hready_out}, 32'h1);
    check(hresp === 2'b00, "R1", "hresp in reset", {30'h0, hresp}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: everything reads zero after reset
    rd1(8'h04, 32'h0, 0, "R1");
    rd1(8'h08, 32'h0, 0, "R1");
    rd1(8'h0C, 32'h0, 0, "R1");
    rd1(8'h10, 32'h0, WAIT, "R1");

    // R3/R7/R9: bursts with the result read right behind the last write
    burst_calc(32'd9, 32'd6, 32'd5, "R3_R7_R9");
    burst_calc(32'd10, 32'd5, 32'd6, "R4_R7");
    burst_calc(32'd10, 32'd5, 32'd7, "R5_R7");

    // R4 with single writes: wrap below zero
    wr1(8'h04, 32'd3);
    wr1(8'h08, 32'd5);
    wr1(8'h0C, 32'd6);
    rd1(8'h10, 32'hFFFF_FFFE, WAIT, "R4_R9");

    // R5: product truncated to 32 bits
    wr1(8'h04, 32'h0001_0000);
    wr1(8'h08, 32'h0001_0003);
    wr1(8'h0C, 32'd7);
    rd1(8'h10, 32'h0003_0000, WAIT, "R5_R9");

    // R2: register readback
    rd1(8'h04, 32'h0001_0000, 0, "R2");
    rd1(8'h08, 32'h0001_0003, 0, "R2");
    rd1(8'h0C, 32'd7, 0, "R2");

    // R6: unknown operation code
    wr1(8'h0C, 32'd13);
    rd1(8'h10, 32'h0, WAIT, "R6");
    wr1(8'h0C, 32'd4);
    rd1(8'h10, 32'h0, WAIT, "R6");

    // R10: IDLE and BUSY transfers do not write
    wr1(8'h04, 32'hDEAD_0001, T_IDLE);
    wr1(8'h04, 32'hDEAD_0002, T_BUSY);
    rd1(8'h04, 32'h0001_0000, 0, "R10");

    // R11: discarded writes
    wr1(8'h0C, 32'd5);
    wr1(8'h10, 32'h0000_1234);
    rd1(8'h10, 32'h0002_0003, WAIT, "R11");
    wr1(8'h14, 32'd6);
    rd1(8'h0C, 32'd5, 0, "R11");
    wr1(8'h04, 32'h0000_0055, T_NSEQ, SZ_HALF);
    wr1(8'h05, 32'h0000_0066);
    rd1(8'h04, 32'h0001_0000, 0, "R11");

    // R12: unmapped reads
    rd1(8'h00, 32'h0, 0, "R12");
    rd1(8'h14, 32'h0, 0, "R12");
    rd1(8'hFF, 32'h0, 0, "R12");

    repeat (6) @(posedge clk);
    #1;
    check(sb_q.size() == 0, "R7", "reads left uncompleted", sb_q.size(), 32'h0);
    check(resp_bad == 0, "R8", "non-OKAY response cycles", resp_bad, 32'h0);
    summary();
    $finish;
  end

endmodule